// File: doc/BRIEF.md
# LPM Attribute Capture and Resume Timer

This block keeps the attributes of one USB Link Power Management transaction in a single 16-bit register and turns the resume field into a timed resume pulse. In device mode the attributes of each incoming LPM request arrive as a one-beat stream word. They are written into the register only when the block that handles the handshake reports that the request was answered with ACK. In host mode software fills the register, and the low nine bits are presented as the attribute payload of the next LPM token to be sent. Software can read and write the register in either mode.

An accepted request whose link-state field asks for sleep (L1) raises a one-cycle entry pulse and puts the block in L1 until a suspend-end input arrives. While in L1 the effective remote-wake permission follows the register's remote-wake bit. Outside L1 it follows the permission negotiated at enumeration. A resume timer clocked by a 1 µs tick drives a resume output for 50 plus 75 times the 4-bit resume code ticks.

The request stream has valid and ready signals. `rx_ready` is held high at all times, so the block never applies back-pressure. A word is consumed in every cycle in which `rx_valid` is high. The sender does not need to hold a word for more than one cycle.

Top module: `lpm_attr_ctrl`

## Requirements
- R1: After reset the register reads 0x0000. Its layout is endpoint in bits 15:12, remote-wake enable in bit 8, resume code in bits 7:4 and link state in bits 3:0. Bits 11:9 always read zero, whatever is written to them.
- R2: In device mode (`host_mode`=0), a stream word with `rx_ack`=1 loads endpoint, remote-wake, resume code and link state into the register. A word with `rx_ack`=0, or any word in host mode, leaves the register unchanged.
- R3: A software write takes effect on the next clock edge in either mode. If a write and an ACK capture occur in the same cycle, the captured attributes are stored and the write is lost.
- R4: `tx_payload` equals register bits 8:0, zero-extended to 11 bits.
- R5: `l1_enter` pulses for one cycle, in the cycle after an ACK capture whose link state is 1. A capture with any other link value still updates the register but gives no pulse and does not enter L1.
- R6: `in_l1` rises together with `l1_enter` and falls one cycle after `suspend_end`. While `in_l1` is high, `rwake_eff` equals register bit 8. Otherwise `rwake_eff` equals `enum_rwake`.
- R7: A `resume_start` pulse while the timer is idle raises `resume_drive` on the next cycle. `resume_drive` stays high for exactly 50 + 75·code cycles in which `tick_us` is high, where code is register bits 7:4. This gives a range of 50 to 1175 ticks.
- R8: The resume code is latched when the timer starts. Register writes during a resume, and further `resume_start` pulses during a resume, do not change its length.
- R9: `rx_ready` is 1 at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 = host, 0 = device |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 16 | Software write data |
| sw_rdata | output | 16 | Register read value |
| rx_valid | input | 1 | Received LPM attribute word valid |
| rx_ready | output | 1 | Always 1 (no back-pressure) |
| rx_ack | input | 1 | The request was answered with ACK |
| rx_endpoint | input | 4 | Token endpoint number |
| rx_rwake | input | 1 | Requested remote-wake enable |
| rx_resume_code | input | 4 | Requested resume code |
| rx_link | input | 4 | Requested link state |
| tx_payload | output | 11 | Host LPM token attribute payload |
| l1_enter | output | 1 | One-cycle pulse on entry to L1 |
| in_l1 | output | 1 | Link is in L1 |
| suspend_end | input | 1 | Current suspend cycle has ended |
| enum_rwake | input | 1 | Remote-wake permission from enumeration |
| rwake_eff | output | 1 | Effective remote-wake permission |
| tick_us | input | 1 | 1 µs enable |
| resume_start | input | 1 | Begin resume signalling |
| resume_drive | output | 1 | Drive resume on the bus |

## Verification
The hardest situations to reach from the ports are coincidences within a single cycle. The first is an ACK capture on the same edge as a software write. The bench aligns both strobes on one edge and checks that the register holds the captured value. The second is a change of resume code in the middle of a resume. The bench lets a resume run, then partway through writes a different code and pulses `resume_start` again, and checks that the tick count still matches the code latched at the start. The bench covers every resume code, using both a continuous tick and a sparse tick. It also covers all sixteen link-state values with ACK and without ACK.

// File: rtl/lpm_attr_pkg.sv
package lpm_attr_pkg;
  localparam int REG_W   = 16;
  localparam int EP_W    = 4;
  localparam int CODE_W  = 4;
  localparam int LINK_W  = 4;
  localparam int PAY_W   = 11;
  localparam logic [LINK_W-1:0] LINK_SLEEP = 4'd1;
  localparam logic [REG_W-1:0]  IMPL_MASK  = 16'hF1FF;

  typedef struct packed {
    logic [EP_W-1:0]   ep;
    logic              rwake;
    logic [CODE_W-1:0] code;
    logic [LINK_W-1:0] link;
  } lpm_attr_t;

  function automatic logic [REG_W-1:0] attr_to_word(input lpm_attr_t a);
    return {a.ep, 3'b000, a.rwake, a.code, a.link};
  endfunction
endpackage

// File: rtl/lpm_attr_store.sv
module lpm_attr_store
  import lpm_attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_mode,
  input  logic             sw_we,
  input  logic [REG_W-1:0] sw_wdata,
  input  logic             rx_valid,
  input  logic             rx_ack,
  input  lpm_attr_t        rx_attr,
  output logic [REG_W-1:0] q,
  output logic             capture
);
  assign capture = !host_mode && rx_valid && rx_ack;

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (capture) q <= attr_to_word(rx_attr);
    else if (sw_we)   q <= sw_wdata & IMPL_MASK;
  end

  a_r1_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    q[11:9] == 3'b000);
  a_r2_no_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !(rx_valid && rx_ack && !host_mode)) |=> $stable(q));
  a_r3_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && sw_we) |=> (q[15:12] == $past(rx_attr.ep) && q[3:0] == $past(rx_attr.link)));
endmodule

// File: rtl/lpm_link_state.sv
module lpm_link_state (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_sleep,
  input  logic suspend_end,
  input  logic lpm_rwake,
  input  logic enum_rwake,
  output logic l1_enter,
  output logic in_l1,
  output logic rwake_eff
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l1_enter <= 1'b0;
      in_l1    <= 1'b0;
    end else begin
      l1_enter <= accept_sleep;
      if (accept_sleep)     in_l1 <= 1'b1;
      else if (suspend_end) in_l1 <= 1'b0;
    end
  end

  assign rwake_eff = in_l1 ? lpm_rwake : enum_rwake;

  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_enter && !accept_sleep) |=> !l1_enter);
  a_r6_enter_sets_l1: assert property (@(posedge clk) disable iff (!rst_n)
    l1_enter |-> in_l1);
  a_r6_suspend_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_end && !accept_sleep) |=> !in_l1);
endmodule

// File: rtl/lpm_resume_timer.sv
module lpm_resume_timer #(
  parameter int BASE_TICKS = 50,
  parameter int STEP_TICKS = 75,
  parameter int CODE_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              resume_start,
  input  logic [CODE_W-1:0] code,
  output logic              resume_drive
);
  localparam int MAX_TICKS = BASE_TICKS + STEP_TICKS * ((1 << CODE_W) - 1);
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] cnt;
  logic             idle;
  logic [CNT_W-1:0] load_val;

  assign idle     = (cnt == '0);
  assign load_val = CNT_W'(BASE_TICKS) + CNT_W'(STEP_TICKS) * CNT_W'(code);

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (idle && resume_start) cnt <= load_val;
    else if (!idle && tick_us)     cnt <= cnt - CNT_W'(1);
  end

  assign resume_drive = !idle;

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !resume_start) |=> !resume_drive);
  a_r7_start_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && resume_start) |=> resume_drive);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !tick_us) |=> $stable(cnt));
  a_r8_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && tick_us) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/lpm_attr_ctrl.sv
module lpm_attr_ctrl
  import lpm_attr_pkg::*;
#(
  parameter int BASE_TICKS = 50,
  parameter int STEP_TICKS = 75
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic              sw_we,
  input  logic [REG_W-1:0]  sw_wdata,
  output logic [REG_W-1:0]  sw_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_ack,
  input  logic [EP_W-1:0]   rx_endpoint,
  input  logic              rx_rwake,
  input  logic [CODE_W-1:0] rx_resume_code,
  input  logic [LINK_W-1:0] rx_link,
  output logic [PAY_W-1:0]  tx_payload,
  output logic              l1_enter,
  output logic              in_l1,
  input  logic              suspend_end,
  input  logic              enum_rwake,
  output logic              rwake_eff,
  input  logic              tick_us,
  input  logic              resume_start,
  output logic              resume_drive
);
  lpm_attr_t        rx_attr;
  logic [REG_W-1:0] attr_q;
  logic             capture;

  assign rx_attr  = '{ep: rx_endpoint, rwake: rx_rwake, code: rx_resume_code, link: rx_link};
  assign rx_ready = 1'b1;

  lpm_attr_store u_store (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .sw_we(sw_we),
    .sw_wdata(sw_wdata), .rx_valid(rx_valid), .rx_ack(rx_ack),
    .rx_attr(rx_attr), .q(attr_q), .capture(capture)
  );

  assign sw_rdata   = attr_q;
  assign tx_payload = PAY_W'(attr_q[8:0]);

  lpm_link_state u_link (
    .clk(clk), .rst_n(rst_n),
    .accept_sleep(capture && (rx_link == LINK_SLEEP)),
    .suspend_end(suspend_end), .lpm_rwake(attr_q[8]),
    .enum_rwake(enum_rwake), .l1_enter(l1_enter), .in_l1(in_l1),
    .rwake_eff(rwake_eff)
  );

  lpm_resume_timer #(
    .BASE_TICKS(BASE_TICKS), .STEP_TICKS(STEP_TICKS), .CODE_W(CODE_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .resume_start(resume_start), .code(attr_q[7:4]),
    .resume_drive(resume_drive)
  );

  a_r5_sleep_only: assert property (@(posedge clk) disable iff (!rst_n)
    l1_enter |-> (sw_rdata[3:0] == LINK_SLEEP));
  a_r9_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready);
endmodule

// File: tb/lpm_attr_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_attr_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_mode = 1'b0, sw_we = 1'b0, rx_valid = 1'b0, rx_ack = 1'b0;
  logic [15:0] sw_wdata = '0;
  logic [15:0] sw_rdata;
  logic rx_ready, rx_rwake = 1'b0;
  logic [3:0] rx_endpoint = '0, rx_resume_code = '0, rx_link = '0;
  logic [10:0] tx_payload;
  logic l1_enter, in_l1, rwake_eff, resume_drive;
  logic suspend_end = 1'b0, enum_rwake = 1'b0, tick_us = 1'b0, resume_start = 1'b0;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lpm_attr_ctrl u_lpm_attr_ctrl (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .sw_we(sw_we),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_ack(rx_ack), .rx_endpoint(rx_endpoint),
    .rx_rwake(rx_rwake), .rx_resume_code(rx_resume_code), .rx_link(rx_link),
    .tx_payload(tx_payload), .l1_enter(l1_enter), .in_l1(in_l1),
    .suspend_end(suspend_end), .enum_rwake(enum_rwake), .rwake_eff(rwake_eff),
    .tick_us(tick_us), .resume_start(resume_start), .resume_drive(resume_drive)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic sw_write(input logic [15:0] d);
    sw_we = 1'b1; sw_wdata = d; step(); sw_we = 1'b0;
  endtask

  task automatic send_req(input logic ack, input logic [3:0] ep, input logic rw,
                          input logic [3:0] code, input logic [3:0] link);
    rx_valid = 1'b1; rx_ack = ack; rx_endpoint = ep; rx_rwake = rw;
    rx_resume_code = code; rx_link = link;
    step();
    rx_valid = 1'b0; rx_ack = 1'b0;
  endtask

  task automatic run_resume(input int code, input int period, input bit disturb);
    int ticks = 0;
    int guard = 0;
    int exp_n = 50 + 75 * code;
    sw_write({4'h0, 3'b0, 1'b0, 4'(code), 4'h0});
    resume_start = 1'b1; step(); resume_start = 1'b0;
    chk("R7 drive after start", 32'(resume_drive), 32'd1);
    while (resume_drive && guard < 20000) begin
      tick_us = ((guard % period) == 0);
      if (disturb && guard == 30) begin
        sw_we = 1'b1; sw_wdata = 16'h00F0; resume_start = 1'b1;
      end
      if (tick_us) ticks++;
      step();
      sw_we = 1'b0; resume_start = 1'b0;
      guard++;
    end
    tick_us = 1'b0;
    if (disturb) chk("R8 latched length", 32'(ticks), 32'(exp_n));
    else         chk("R7 resume ticks", 32'(ticks), 32'(exp_n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_reg;
    repeat (3) step();
    rst_n = 1'b1; step();
    chk("R1 reset value", 32'(sw_rdata), 32'h0);
    chk("R9 ready", 32'(rx_ready), 32'd1);
    chk("R6 reset in_l1", 32'(in_l1), 32'd0);

    // R1: unimplemented bits
    sw_write(16'hFFFF);
    chk("R1 bits 11:9 zero", 32'(sw_rdata), 32'hF1FF);
    chk("R4 payload", 32'(tx_payload), 32'h1FF);
    sw_write(16'h0000);

    // R2/R5: sweep all link states, with and without ACK
    exp_reg = 16'h0000;
    for (int l = 0; l < 16; l++) begin
      send_req(1'b0, 4'(15 - l), l[0], 4'(l), 4'(l));
      chk("R2 nack hold", 32'(sw_rdata), 32'(exp_reg));
      chk("R5 no pulse on nack", 32'(l1_enter), 32'd0);
      send_req(1'b1, 4'(l), l[1], 4'(15 - l), 4'(l));
      exp_reg = {4'(l), 3'b0, l[1], 4'(15 - l), 4'(l)};
      chk("R2 ack capture", 32'(sw_rdata), 32'(exp_reg));
      chk("R4 payload", 32'(tx_payload), 32'(exp_reg[8:0]));
      chk("R5 pulse only for sleep", 32'(l1_enter), 32'(l == 1));
      chk("R5 in_l1 only for sleep", 32'(in_l1), 32'(l == 1));
      step();
      chk("R5 pulse one cycle", 32'(l1_enter), 32'd0);
      suspend_end = 1'b1; step(); suspend_end = 1'b0;
      chk("R6 suspend end clears", 32'(in_l1), 32'd0);
    end

    // R2: host mode ignores captures
    host_mode = 1'b1;
    send_req(1'b1, 4'h9, 1'b1, 4'h9, 4'h1);
    chk("R2 host ignores rx", 32'(sw_rdata), 32'(exp_reg));
    chk("R5 host no L1", 32'(in_l1), 32'd0);
    sw_write(16'hA1C5);
    chk("R3 host write", 32'(sw_rdata), 32'hA1C5 & 32'hF1FF);
    chk("R4 host payload", 32'(tx_payload), 32'h1C5);
    host_mode = 1'b0;

    // R3: collision, capture wins
    sw_we = 1'b1; sw_wdata = 16'h5555;
    send_req(1'b1, 4'h3, 1'b0, 4'h2, 4'h4);
    sw_we = 1'b0;
    chk("R3 capture beats write", 32'(sw_rdata), 32'h3024);
    // write alone in device mode while no rx
    sw_write(16'h7000);
    chk("R3 device write", 32'(sw_rdata), 32'h7000);

    // R6: remote wake selection
    for (int e = 0; e < 2; e++) begin
      enum_rwake = e[0];
      send_req(1'b1, 4'h2, ~e[0], 4'h0, 4'h1);
      chk("R6 rwake from LPM in L1", 32'(rwake_eff), 32'(~e[0] & 1'b1));
      suspend_end = 1'b1; step(); suspend_end = 1'b0;
      chk("R6 rwake from enum after suspend", 32'(rwake_eff), 32'(e));
    end
    enum_rwake = 1'b0;

    // R7: every code, continuous tick and sparse tick
    for (int c = 0; c < 16; c++) run_resume(c, 1, 1'b0);
    run_resume(2, 3, 1'b0);
    run_resume(0, 4, 1'b0);
    // R8: write and restart mid-resume do not change length
    run_resume(3, 1, 1'b1);
    run_resume(1, 2, 1'b1);
    step();
    chk("R7 idle after resume", 32'(resume_drive), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule